// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

This block shares one result broadcast lane among seven execution units in an out-of-order core. Every cycle each unit may offer a finished result made of a reorder-buffer tag, a 64-bit value and an exception flag. The arbiter picks one offer by a fixed ranking that favours integer work. It drives the winner onto the broadcast lane, where waiting reservation-station operands pick it up and the reorder buffer marks the tagged entry complete.

Results are never lost. A unit that loses arbitration parks its result in its own one-entry holding slot. The unit is stalled only while that slot is occupied and is not being drained in the current cycle. A parked result competes at its unit's rank and always goes out before a newer live result from the same unit. When a pipeline flush arrives, parked results from instructions younger than the flush point are discarded. Age is measured from the reorder-buffer head.

Top module: `cdb_result_arbiter`

## Requirements
- R1: At most one result is broadcast per cycle, and `bus_valid_o` is high in every cycle in which any unit has a live valid offer or an occupied holding slot.
- R2: Unit index sets rank, and index 0 is highest: 0 multiply, 1 memory, 2 integer ALU, 3 integer divide, 4 FP divide, 5 FP multiply, 6 FP add. The broadcast comes from the lowest-indexed unit that requests.
- R3: A live result that is accepted but not granted is stored in its unit's holding slot. It is broadcast unchanged in a later cycle unless a flush removes it.
- R4: `fu_ready_o[i]` is low exactly when unit i's holding slot is occupied and unit i is not granted this cycle. A live offer made while ready is low is not taken.
- R5: When a unit's holding slot is occupied, that unit's grant carries the held result and not the live one. A live offer made in the same cycle is accepted into the freed slot.
- R6: In a cycle with `flush_valid_i` high, a held or newly parked result is dropped if its tag is strictly younger than `flush_tag_i`. A tag is younger when (tag − `rob_head_i`) mod 2^TAG_W is greater than (`flush_tag_i` − `rob_head_i`) mod 2^TAG_W. Equal and older tags are kept.
- R7: The broadcast tag, 64-bit value and exception flag equal those of the granted result bit for bit. Unit i's fields sit at `fu_tag_i[i*TAG_W +: TAG_W]`, `fu_data_i[i*DATA_W +: DATA_W]` and `fu_exc_i[i]`.
- R8: After reset, all holding slots are empty, all ready outputs are high, and no broadcast is made until a unit offers a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fu_valid_i | input | NUM_UNITS | Live result offer, one bit per unit |
| fu_tag_i | input | NUM_UNITS*TAG_W | Reorder-buffer tags, packed by unit |
| fu_data_i | input | NUM_UNITS*DATA_W | Result values, packed by unit |
| fu_exc_i | input | NUM_UNITS | Exception flags, one bit per unit |
| fu_ready_o | output | NUM_UNITS | Live offer is accepted this cycle |
| flush_valid_i | input | 1 | Flush request |
| flush_tag_i | input | TAG_W | Tag of the flush point |
| rob_head_i | input | TAG_W | Oldest in-flight reorder-buffer tag |
| bus_valid_o | output | 1 | Broadcast lane carries a result |
| bus_tag_o | output | TAG_W | Broadcast tag |
| bus_data_o | output | DATA_W | Broadcast value |
| bus_exc_o | output | 1 | Broadcast exception flag |

## Verification
The bench goes after the cycle in which every unit fires at once. A wrong ranking would show up as the wrong tag on the lane, and a slot that fails to capture would make later results vanish. It keeps offering new live results while slots are full, which catches a ready signal that stays high and overwrites a parked result, or a live result that overtakes its older parked one. Flushes are driven with heads placed so that tag order wraps around. This exposes an age test that compares raw tags, because such a design would drop old work or let squashed work reach the lane.

// File: rtl/cdb_arb_pkg.sv
package cdb_arb_pkg;

   // Rank of each execution unit on the broadcast lane; lower index wins.
   localparam int unsigned UNIT_MUL   = 0;
   localparam int unsigned UNIT_MEM   = 1;
   localparam int unsigned UNIT_ALU   = 2;
   localparam int unsigned UNIT_DIV   = 3;
   localparam int unsigned UNIT_FDIV  = 4;
   localparam int unsigned UNIT_FMUL  = 5;
   localparam int unsigned UNIT_FADD  = 6;
   localparam int unsigned UNIT_COUNT = 7;

   // True when tag is strictly younger than ref_tag, with ages taken
   // as distance from the reorder-buffer head modulo 2**width.
   function automatic logic tag_younger(input logic [31:0] tag,
                                        input logic [31:0] ref_tag,
                                        input logic [31:0] head,
                                        input int unsigned width);
      logic [31:0] mask;
      logic [31:0] age_t;
      logic [31:0] age_r;
      mask  = (32'd1 << width) - 32'd1;
      age_t = (tag - head) & mask;
      age_r = (ref_tag - head) & mask;
      return age_t > age_r;
   endfunction

endpackage

// File: rtl/cdb_hold_slot.sv
module cdb_hold_slot #(
   parameter int unsigned TAG_W  = 5,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live_valid_i,
   input  logic [TAG_W-1:0]  live_tag_i,
   input  logic [DATA_W-1:0] live_data_i,
   input  logic              live_exc_i,
   output logic              live_ready_o,
   input  logic              grant_i,
   input  logic              flush_i,
   input  logic [TAG_W-1:0]  flush_tag_i,
   input  logic [TAG_W-1:0]  head_i,
   output logic              req_o,
   output logic [TAG_W-1:0]  cand_tag_o,
   output logic [DATA_W-1:0] cand_data_o,
   output logic              cand_exc_o
);
   import cdb_arb_pkg::*;

   logic              hold_v;
   logic [TAG_W-1:0]  hold_tag;
   logic [DATA_W-1:0] hold_data;
   logic              hold_exc;

   logic              nxt_v;
   logic [TAG_W-1:0]  nxt_tag;
   logic [DATA_W-1:0] nxt_data;
   logic              nxt_exc;
   logic              accept;

   assign req_o        = hold_v | live_valid_i;
   assign live_ready_o = ~hold_v | grant_i;
   assign accept       = live_valid_i & live_ready_o;

   assign cand_tag_o  = hold_v ? hold_tag  : live_tag_i;
   assign cand_data_o = hold_v ? hold_data : live_data_i;
   assign cand_exc_o  = hold_v ? hold_exc  : live_exc_i;

   always_comb begin
      nxt_v    = hold_v;
      nxt_tag  = hold_tag;
      nxt_data = hold_data;
      nxt_exc  = hold_exc;
      if (hold_v) begin
         if (grant_i) begin
            nxt_v    = accept;
            nxt_tag  = live_tag_i;
            nxt_data = live_data_i;
            nxt_exc  = live_exc_i;
         end
      end else if (accept && !grant_i) begin
         nxt_v    = 1'b1;
         nxt_tag  = live_tag_i;
         nxt_data = live_data_i;
         nxt_exc  = live_exc_i;
      end
      if (flush_i && nxt_v &&
          tag_younger(32'(nxt_tag), 32'(flush_tag_i), 32'(head_i), TAG_W)) begin
         nxt_v = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_tag  <= '0;
         hold_data <= '0;
         hold_exc  <= 1'b0;
      end else begin
         hold_v    <= nxt_v;
         hold_tag  <= nxt_tag;
         hold_data <= nxt_data;
         hold_exc  <= nxt_exc;
      end
   end

   AST_PARK_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
      (live_valid_i && live_ready_o && !grant_i && !flush_i) |=> hold_v) // R3
      else $error("lost live result not parked");

   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && !grant_i && !flush_i) |=> (hold_v && $stable(hold_tag) && $stable(hold_data) && $stable(hold_exc))) // R3
      else $error("parked result changed while waiting");

   AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v && !grant_i && live_valid_i && !flush_i) |=> (hold_v && $stable(hold_tag))) // R4
      else $error("live offer taken while slot busy");

   AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !(hold_v && tag_younger(32'(hold_tag), 32'($past(flush_tag_i)),
                                          32'($past(head_i)), TAG_W))) // R6
      else $error("squashed result survived flush");

endmodule

// File: rtl/cdb_prio_pick.sv
module cdb_prio_pick #(
   parameter int unsigned NUM_REQ   = 7,
   parameter bit          USE_CHAIN = 1'b1
) (
   input  logic [NUM_REQ-1:0] req_i,
   output logic [NUM_REQ-1:0] grant_o
);
   generate
      if (USE_CHAIN) begin : g_chain
         logic [NUM_REQ:0] higher;
         assign higher[0] = 1'b0;
         for (genvar i = 0; i < NUM_REQ; i++) begin : g_bit
            assign higher[i+1] = higher[i] | req_i[i];
            assign grant_o[i]  = req_i[i] & ~higher[i];
         end
      end else begin : g_scan
         always_comb begin
            logic found;
            found   = 1'b0;
            grant_o = '0;
            for (int i = 0; i < NUM_REQ; i++) begin
               if (req_i[i] && !found) begin
                  grant_o[i] = 1'b1;
                  found      = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cdb_bus_mux.sv
module cdb_bus_mux #(
   parameter int unsigned NUM_REQ = 7,
   parameter int unsigned TAG_W   = 5,
   parameter int unsigned DATA_W  = 64
) (
   input  logic [NUM_REQ-1:0]        grant_i,
   input  logic [NUM_REQ*TAG_W-1:0]  tag_i,
   input  logic [NUM_REQ*DATA_W-1:0] data_i,
   input  logic [NUM_REQ-1:0]        exc_i,
   output logic                      valid_o,
   output logic [TAG_W-1:0]          tag_o,
   output logic [DATA_W-1:0]         data_o,
   output logic                      exc_o
);
   always_comb begin
      valid_o = 1'b0;
      tag_o   = '0;
      data_o  = '0;
      exc_o   = 1'b0;
      for (int i = 0; i < NUM_REQ; i++) begin
         valid_o = valid_o | grant_i[i];
         tag_o   = tag_o  | ({TAG_W{grant_i[i]}}  & tag_i[i*TAG_W +: TAG_W]);
         data_o  = data_o | ({DATA_W{grant_i[i]}} & data_i[i*DATA_W +: DATA_W]);
         exc_o   = exc_o  | (grant_i[i] & exc_i[i]);
      end
   end
endmodule

// File: rtl/cdb_result_arbiter.sv
module cdb_result_arbiter #(
   parameter int unsigned NUM_UNITS = cdb_arb_pkg::UNIT_COUNT,
   parameter int unsigned TAG_W     = 5,
   parameter int unsigned DATA_W    = 64,
   parameter bit          USE_CHAIN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_UNITS-1:0]        fu_valid_i,
   input  logic [NUM_UNITS*TAG_W-1:0]  fu_tag_i,
   input  logic [NUM_UNITS*DATA_W-1:0] fu_data_i,
   input  logic [NUM_UNITS-1:0]        fu_exc_i,
   output logic [NUM_UNITS-1:0]        fu_ready_o,
   input  logic                        flush_valid_i,
   input  logic [TAG_W-1:0]            flush_tag_i,
   input  logic [TAG_W-1:0]            rob_head_i,
   output logic                        bus_valid_o,
   output logic [TAG_W-1:0]            bus_tag_o,
   output logic [DATA_W-1:0]           bus_data_o,
   output logic                        bus_exc_o
);
   localparam int unsigned TAG_BITS  = NUM_UNITS * TAG_W;
   localparam int unsigned DATA_BITS = NUM_UNITS * DATA_W;

   generate
      if (NUM_UNITS < 2 || NUM_UNITS > 32) begin : g_bad_units
         $error("NUM_UNITS must lie in 2..32");
      end
      if (TAG_W < 1 || TAG_W > 16) begin : g_bad_tag
         $error("TAG_W must lie in 1..16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [NUM_UNITS-1:0] req;
   logic [NUM_UNITS-1:0] grant;
   logic [TAG_BITS-1:0]  cand_tag;
   logic [DATA_BITS-1:0] cand_data;
   logic [NUM_UNITS-1:0] cand_exc;

   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
         cdb_hold_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .live_valid_i (fu_valid_i[u]),
            .live_tag_i   (fu_tag_i[u*TAG_W +: TAG_W]),
            .live_data_i  (fu_data_i[u*DATA_W +: DATA_W]),
            .live_exc_i   (fu_exc_i[u]),
            .live_ready_o (fu_ready_o[u]),
            .grant_i      (grant[u]),
            .flush_i      (flush_valid_i),
            .flush_tag_i  (flush_tag_i),
            .head_i       (rob_head_i),
            .req_o        (req[u]),
            .cand_tag_o   (cand_tag[u*TAG_W +: TAG_W]),
            .cand_data_o  (cand_data[u*DATA_W +: DATA_W]),
            .cand_exc_o   (cand_exc[u])
         );
      end
   endgenerate

   cdb_prio_pick #(.NUM_REQ(NUM_UNITS), .USE_CHAIN(USE_CHAIN)) i_pick (
      .req_i   (req),
      .grant_o (grant)
   );

   cdb_bus_mux #(.NUM_REQ(NUM_UNITS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_mux (
      .grant_i (grant),
      .tag_i   (cand_tag),
      .data_i  (cand_data),
      .exc_i   (cand_exc),
      .valid_o (bus_valid_o),
      .tag_o   (bus_tag_o),
      .data_o  (bus_data_o),
      .exc_o   (bus_exc_o)
   );

   AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)) // R1
      else $error("more than one grant");

   AST_NO_IDLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (|fu_valid_i) |-> bus_valid_o) // R1
      else $error("offer pending but lane idle");

   generate
      for (genvar p = 1; p < NUM_UNITS; p++) begin : g_rank_chk
         AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            grant[p] |-> !(|req[p-1:0])) // R2
            else $error("lower-ranked unit granted over higher one");
      end
   endgenerate

endmodule

// File: tb/test_cdb_result_arbiter.sv
module test_cdb_result_arbiter;
   localparam int N  = 7;
   localparam int TW = 5;
   localparam int DW = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    fu_valid_i = '0;
   logic [N*TW-1:0] fu_tag_i = '0;
   logic [N*DW-1:0] fu_data_i = '0;
   logic [N-1:0]    fu_exc_i = '0;
   logic [N-1:0]    fu_ready_o;
   logic            flush_valid_i = 1'b0;
   logic [TW-1:0]   flush_tag_i = '0;
   logic [TW-1:0]   rob_head_i = '0;
   logic            bus_valid_o;
   logic [TW-1:0]   bus_tag_o;
   logic [DW-1:0]   bus_data_o;
   logic            bus_exc_o;

   cdb_result_arbiter i_cdb_result_arbiter (
      .clk(clk), .rst_n(rst_n),
      .fu_valid_i(fu_valid_i), .fu_tag_i(fu_tag_i), .fu_data_i(fu_data_i),
      .fu_exc_i(fu_exc_i), .fu_ready_o(fu_ready_o),
      .flush_valid_i(flush_valid_i), .flush_tag_i(flush_tag_i),
      .rob_head_i(rob_head_i),
      .bus_valid_o(bus_valid_o), .bus_tag_o(bus_tag_o),
      .bus_data_o(bus_data_o), .bus_exc_o(bus_exc_o)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference state: parked results and pending live offers
   bit          hv [N];
   int          ht [N];
   logic [63:0] hd [N];
   bit          he [N];
   bit          pv [N];
   int          pt [N];
   logic [63:0] pd [N];
   bit          pe [N];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit younger(input int t, input int r, input int h);
      return ((t - h) & 31) > ((r - h) & 31);
   endfunction

   task automatic offer(input int u, input int tag, input logic [63:0] d, input bit e);
      pv[u] = 1; pt[u] = tag; pd[u] = d; pe[u] = e;
   endtask

   // one clock: drive at falling edge, compare, advance the model
   task automatic step(input bit fl, input int ftag, input int head);
      int win;
      bit rdy [N];
      bit acc;
      for (int i = 0; i < N; i++) begin
         fu_valid_i[i] = pv[i];
         fu_tag_i[i*TW +: TW] = pt[i][TW-1:0];
         fu_data_i[i*DW +: DW] = pd[i];
         fu_exc_i[i] = pe[i];
      end
      flush_valid_i = fl;
      flush_tag_i   = ftag[TW-1:0];
      rob_head_i    = head[TW-1:0];
      #2;
      win = -1;
      for (int i = N - 1; i >= 0; i--) if (hv[i] || pv[i]) win = i;
      chk(bus_valid_o == (win >= 0), "R1 bus_valid", 64'(bus_valid_o), 64'(win >= 0));
      if (win >= 0) begin
         chk(int'(bus_tag_o) == (hv[win] ? ht[win] : pt[win]), "R2/R3/R5 tag",
             64'(bus_tag_o), 64'(hv[win] ? ht[win] : pt[win]));
         chk(bus_data_o == (hv[win] ? hd[win] : pd[win]), "R7 data",
             bus_data_o, hv[win] ? hd[win] : pd[win]);
         chk(bus_exc_o == (hv[win] ? he[win] : pe[win]), "R7 exc",
             64'(bus_exc_o), 64'(hv[win] ? he[win] : pe[win]));
      end
      for (int i = 0; i < N; i++) begin
         rdy[i] = !hv[i] || (win == i);
         chk(fu_ready_o[i] == rdy[i], "R4 ready", 64'(fu_ready_o[i]), 64'(rdy[i]));
      end
      for (int i = 0; i < N; i++) begin
         acc = pv[i] && rdy[i];
         if (hv[i]) begin
            if (win == i) begin
               hv[i] = acc; ht[i] = pt[i]; hd[i] = pd[i]; he[i] = pe[i];
            end
         end else if (acc && win != i) begin
            hv[i] = 1; ht[i] = pt[i]; hd[i] = pd[i]; he[i] = pe[i];
         end
         if (fl && hv[i] && younger(ht[i], ftag, head)) hv[i] = 0;
         if (acc) pv[i] = 0;
      end
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         hv[i] = 0; pv[i] = 0; ht[i] = 0; pt[i] = 0;
         hd[i] = '0; pd[i] = '0; he[i] = 0; pe[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R8: empty after reset
      chk(fu_ready_o == '1, "R8 ready after reset", 64'(fu_ready_o), 64'h7f);
      chk(bus_valid_o == 1'b0, "R8 idle after reset", 64'(bus_valid_o), 64'h0);
      @(negedge clk);
      step(0, 0, 0);

      // R2/R3: all units fire together, then drain in rank order
      for (int u = 0; u < N; u++) offer(u, u + 1, {32'hA000 + u, 32'h1}, u[0]);
      step(0, 0, 0);
      // R4/R5: new offers while slots are full
      for (int u = 0; u < N; u++) offer(u, u + 10, {32'hB000 + u, 32'h2}, ~u[0]);
      for (int k = 0; k < 16; k++) step(0, 0, 0);
      chk(bus_valid_o == 1'b0, "R3 all drained", 64'(bus_valid_o), 64'h0);

      // R6: flush drops younger parked tags, keeps older ones
      offer(0, 2, 64'h11, 0); offer(5, 5, 64'h55, 0); offer(6, 20, 64'h66, 1);
      step(0, 0, 0);
      step(1, 10, 0);
      #2;
      chk(bus_valid_o == 1'b0, "R6 younger dropped", 64'(bus_valid_o), 64'h0);
      step(0, 0, 0);

      // R6 wrap-around: head 28, flush at 30; tag 2 is younger, 29 is older
      offer(0, 1, 64'h1, 0); offer(3, 2, 64'h2, 0); offer(4, 29, 64'h3, 1);
      step(0, 0, 28);
      step(1, 30, 28);
      #2;
      chk(bus_valid_o && bus_tag_o == 5'd29, "R6 wrap keeps older",
          64'(bus_tag_o), 64'd29);
      step(0, 0, 28);

      // random traffic with occasional flushes
      for (int c = 0; c < 5000; c++) begin
         int h;
         h = $urandom_range(0, 31);
         for (int u = 0; u < N; u++)
            if (!pv[u] && $urandom_range(0, 99) < 45)
               offer(u, $urandom_range(0, 31), {$urandom, $urandom}, $urandom_range(0, 1) == 1);
         step($urandom_range(0, 99) < 6, $urandom_range(0, 31), h);
      end
      for (int k = 0; k < 20; k++) step(0, 0, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule